// File: doc/BRIEF.md
# Row/Column Broadcast Context Memory

This block holds the configuration words for an 8 by 8 array of processing cells and hands one selected word to each row, or to each column, of the array. It has two independent banks. The row bank feeds the eight row lanes and the column bank feeds the eight column lanes. Each bank is split into eight lane sets, and each set holds sixteen 32-bit context words. Because the banks are separate, one bank can be refilled while the array runs from the other.

A load command names a bank, a lane set, a starting word index and a word count. The words then arrive one at a time on a valid/ready stream, and the index steps forward by one for each word. An execute request names a broadcast mode and a word index, plus an eight-bit lane enable. One cycle later the enabled lanes present the addressed word from their own set, and a valid strobe marks the update. Lanes that are not enabled keep the word they already had.

Top module: `ctx_bcast_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, bc_valid, bc_lane_vld, bc_ctx, ld_ready and wr_conflict are all zero and bc_mode is 0 (row).
- R2: A ld_start accepted while idle, with ld_count from 1 to 16, raises ld_ready on the next cycle. ld_ready stays high until exactly ld_count words have been accepted (cycles with ld_valid and ld_ready both high) and then drops. A ld_start with ld_count of 0 or above 16 is ignored, and so is a ld_start given while a burst is active.
- R3: The k-th accepted word of a burst (k from 0) is stored at word index (ld_base + k) mod 16 of the chosen set, so a burst wraps inside its set and never touches another set or bank. ld_bank 0 selects the row bank and ld_bank 1 the column bank.
- R4: An execute with ex_mode 0 (row) drives, on the cycle after the request, lane i of bc_ctx (bits 32i+31 down to 32i) with word ex_addr of row-bank set i, for every enabled lane i.
- R5: An execute with ex_mode 1 (column) drives enabled lane i with word ex_addr of column-bank set i, with the same one-cycle latency.
- R6: bc_lane_vld equals the ex_lane_en of the previous cycle's request, or zero when there was no request. A lane that is not updated keeps its previous context.
- R7: bc_valid is high exactly on the cycle after each ex_valid. bc_mode takes the mode of that request and holds its value otherwise.
- R8: When a load word is written in the same cycle as an execute that reads the same bank, set and index, the broadcast carries the word that was stored before the write. The new word is seen by later executes.
- R9: wr_conflict is high on the cycle after a load word is accepted into the bank that an execute request in that same cycle reads. It is low otherwise.
- R10: Loading one bank while executes read the other bank raises no conflict and leaves the broadcast values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_start | input | 1 | Starts a load burst |
| ld_bank | input | 1 | Target bank: 0 is row, 1 is column |
| ld_set | input | 3 | Target lane set within the bank |
| ld_base | input | 4 | First word index of the burst |
| ld_count | input | 5 | Number of words in the burst, 1 to 16 |
| ld_valid | input | 1 | Load word present |
| ld_data | input | 32 | Load word |
| ld_ready | output | 1 | Burst active; a word is taken when ld_valid is also high |
| ex_valid | input | 1 | Execute request |
| ex_mode | input | 1 | Broadcast mode: 0 is row, 1 is column |
| ex_addr | input | 4 | Word index to broadcast |
| ex_lane_en | input | 8 | Per-lane enable for this request |
| bc_valid | output | 1 | A broadcast update took place this cycle |
| bc_mode | output | 1 | Mode of the most recent broadcast |
| bc_lane_vld | output | 8 | Lanes updated this cycle |
| bc_ctx | output | 256 | Eight lane contexts, lane i in bits 32i+31 down to 32i |
| wr_conflict | output | 1 | A load word landed in the bank being executed |

## Verification
Every set of both banks is filled with words that encode their bank, set, index and load round. Because of that encoding, a lane that reads from the wrong bank, set or index shows a visibly wrong value. One column-bank fill starts in the middle of the set so that it wraps, and a later short burst wraps from index 14 to 1 while the neighbouring set is left as it was. Row and column executes alternate with changing index and lane-enable patterns, which tells a correct hold on disabled lanes apart from a clear or a stray update. Three directed cases cover the overlap timing: a write and a read to the same index in one cycle, a load into the executing bank, and a load into the idle bank during back-to-back executes. These separate read-before-write from write-through and show when wr_conflict should and should not fire.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;

    localparam int CTX_W      = 32;
    localparam int LANE_CNT   = 8;
    localparam int SET_DEPTH  = 16;

    typedef enum logic {
        BC_ROW = 1'b0,
        BC_COL = 1'b1
    } bc_mode_e;

    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_BURST = 1'b1
    } ld_state_e;

    function automatic int unsigned wrap_next(int unsigned idx, int unsigned depth);
        return (idx + 1) % depth;
    endfunction

endpackage

// File: rtl/ctx_loader.sv
`timescale 1ns/1ps
module ctx_loader
    import ctx_pkg::*;
#(
    parameter int DEPTH = SET_DEPTH,
    parameter int LANES = LANE_CNT,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(LANES),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_start,
    input  logic            ld_bank,
    input  logic [SW-1:0]   ld_set,
    input  logic [AW-1:0]   ld_base,
    input  logic [CNTW-1:0] ld_count,
    input  logic            ld_valid,
    output logic            ld_ready,
    output logic            wr_en,
    output logic            wr_bank,
    output logic [SW-1:0]   wr_set,
    output logic [AW-1:0]   wr_addr
);

    ld_state_e       state_q;
    logic            bank_q;
    logic [SW-1:0]   set_q;
    logic [AW-1:0]   ptr_q;
    logic [CNTW-1:0] left_q;
    logic            start_ok;

    assign start_ok = ld_start && (ld_count != '0) && (ld_count <= CNTW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            bank_q  <= 1'b0;
            set_q   <= '0;
            ptr_q   <= '0;
            left_q  <= '0;
        end else begin
            case (state_q)
                LD_IDLE: begin
                    if (start_ok) begin
                        state_q <= LD_BURST;
                        bank_q  <= ld_bank;
                        set_q   <= ld_set;
                        ptr_q   <= ld_base;
                        left_q  <= ld_count;
                    end
                end
                LD_BURST: begin
                    if (ld_valid) begin
                        ptr_q  <= AW'(wrap_next(int'(ptr_q), DEPTH));
                        left_q <= left_q - 1'b1;
                        if (left_q == CNTW'(1)) begin
                            state_q <= LD_IDLE;
                        end
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assign ld_ready = (state_q == LD_BURST);
    assign wr_en    = ld_ready && ld_valid;
    assign wr_bank  = bank_q;
    assign wr_set   = set_q;
    assign wr_addr  = ptr_q;

endmodule

// File: rtl/ctx_bank.sv
`timescale 1ns/1ps
module ctx_bank
    import ctx_pkg::*;
#(
    parameter int LANES = LANE_CNT,
    parameter int DEPTH = SET_DEPTH,
    parameter int CW    = CTX_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [SW-1:0]      wr_set,
    input  logic [AW-1:0]      wr_addr,
    input  logic [CW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [LANES*CW-1:0] rd_words
);

    for (genvar g = 0; g < LANES; g++) begin : g_set
        logic [CW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wr_set == SW'(g))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_words[g*CW +: CW] = mem[rd_addr];
    end

endmodule

// File: rtl/ctx_bcast.sv
`timescale 1ns/1ps
module ctx_bcast
    import ctx_pkg::*;
#(
    parameter int LANES = LANE_CNT,
    parameter int CW    = CTX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ex_valid,
    input  logic                ex_mode,
    input  logic [LANES-1:0]    ex_lane_en,
    input  logic [LANES*CW-1:0] row_words,
    input  logic [LANES*CW-1:0] col_words,
    output logic                bc_valid,
    output logic                bc_mode,
    output logic [LANES-1:0]    bc_lane_vld,
    output logic [LANES*CW-1:0] bc_ctx
);

    bc_mode_e mode_sel;
    assign mode_sel = bc_mode_e'(ex_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            bc_valid    <= 1'b0;
            bc_mode     <= BC_ROW;
            bc_lane_vld <= '0;
        end else begin
            bc_valid    <= ex_valid;
            bc_lane_vld <= ex_valid ? ex_lane_en : '0;
            if (ex_valid) begin
                bc_mode <= mode_sel;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW-1:0] pick;
        assign pick = (mode_sel == BC_COL) ? col_words[g*CW +: CW]
                                           : row_words[g*CW +: CW];

        always_ff @(posedge clk) begin
            if (rst) begin
                bc_ctx[g*CW +: CW] <= '0;
            end else if (ex_valid && ex_lane_en[g]) begin
                bc_ctx[g*CW +: CW] <= pick;
            end
        end
    end

endmodule

// File: rtl/ctx_bcast_mem.sv
`timescale 1ns/1ps
module ctx_bcast_mem
    import ctx_pkg::*;
#(
    parameter int LANES = LANE_CNT,
    parameter int DEPTH = SET_DEPTH,
    parameter int CW    = CTX_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(LANES),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_start,
    input  logic                ld_bank,
    input  logic [SW-1:0]       ld_set,
    input  logic [AW-1:0]       ld_base,
    input  logic [CNTW-1:0]     ld_count,
    input  logic                ld_valid,
    input  logic [CW-1:0]       ld_data,
    output logic                ld_ready,
    input  logic                ex_valid,
    input  logic                ex_mode,
    input  logic [AW-1:0]       ex_addr,
    input  logic [LANES-1:0]    ex_lane_en,
    output logic                bc_valid,
    output logic                bc_mode,
    output logic [LANES-1:0]    bc_lane_vld,
    output logic [LANES*CW-1:0] bc_ctx,
    output logic                wr_conflict
);

    logic            wr_en;
    logic            wr_bank;
    logic [SW-1:0]   wr_set;
    logic [AW-1:0]   wr_addr;
    logic [LANES*CW-1:0] bank_words [2];

    ctx_loader #(.DEPTH(DEPTH), .LANES(LANES)) u_loader (
        .clk      (clk),
        .rst      (rst),
        .ld_start (ld_start),
        .ld_bank  (ld_bank),
        .ld_set   (ld_set),
        .ld_base  (ld_base),
        .ld_count (ld_count),
        .ld_valid (ld_valid),
        .ld_ready (ld_ready),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_set   (wr_set),
        .wr_addr  (wr_addr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        ctx_bank #(.LANES(LANES), .DEPTH(DEPTH), .CW(CW)) u_bank (
            .clk      (clk),
            .we       (wr_en && (wr_bank == 1'(b))),
            .wr_set   (wr_set),
            .wr_addr  (wr_addr),
            .wr_data  (ld_data),
            .rd_addr  (ex_addr),
            .rd_words (bank_words[b])
        );
    end

    ctx_bcast #(.LANES(LANES), .CW(CW)) u_bcast (
        .clk         (clk),
        .rst         (rst),
        .ex_valid    (ex_valid),
        .ex_mode     (ex_mode),
        .ex_lane_en  (ex_lane_en),
        .row_words   (bank_words[BC_ROW]),
        .col_words   (bank_words[BC_COL]),
        .bc_valid    (bc_valid),
        .bc_mode     (bc_mode),
        .bc_lane_vld (bc_lane_vld),
        .bc_ctx      (bc_ctx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_conflict <= 1'b0;
        end else begin
            wr_conflict <= wr_en && ex_valid && (ex_mode == wr_bank);
        end
    end

endmodule

// File: rtl/ctx_bcast_mem_chk.sv
`timescale 1ns/1ps
module ctx_bcast_mem_chk #(
    parameter int LANES = 8,
    parameter int CW    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                ld_start,
    input logic                ld_valid,
    input logic                ld_ready,
    input logic                ex_valid,
    input logic [LANES-1:0]    ex_lane_en,
    input logic                bc_valid,
    input logic [LANES-1:0]    bc_lane_vld,
    input logic [LANES*CW-1:0] bc_ctx,
    input logic                wr_conflict
);

    assert_ready_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_ready) |-> $past(ld_start));

    assert_valid_follows_req_R7: assert property (@(posedge clk) disable iff (rst)
        bc_valid |-> $past(ex_valid));

    assert_req_gives_valid_R7: assert property (@(posedge clk) disable iff (rst)
        ex_valid |=> bc_valid);

    assert_lane_vld_matches_R6: assert property (@(posedge clk) disable iff (rst)
        ex_valid |=> (bc_lane_vld == $past(ex_lane_en)));

    assert_no_lane_vld_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !ex_valid |=> (bc_lane_vld == '0));

    assert_conflict_cause_R9: assert property (@(posedge clk) disable iff (rst)
        wr_conflict |-> $past(ex_valid && ld_valid && ld_ready));

    for (genvar g = 0; g < LANES; g++) begin : g_hold
        assert_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !bc_lane_vld[g] |-> $stable(bc_ctx[g*CW +: CW]));
    end

endmodule

bind ctx_bcast_mem ctx_bcast_mem_chk #(.LANES(LANES), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_start    (ld_start),
    .ld_valid    (ld_valid),
    .ld_ready    (ld_ready),
    .ex_valid    (ex_valid),
    .ex_lane_en  (ex_lane_en),
    .bc_valid    (bc_valid),
    .bc_lane_vld (bc_lane_vld),
    .bc_ctx      (bc_ctx),
    .wr_conflict (wr_conflict)
);

// File: tb/test_ctx_bcast_mem.sv
`timescale 1ns/1ps
module test_ctx_bcast_mem;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ld_start = 1'b0;
    logic         ld_bank = 1'b0;
    logic [2:0]   ld_set = '0;
    logic [3:0]   ld_base = '0;
    logic [4:0]   ld_count = '0;
    logic         ld_valid = 1'b0;
    logic [31:0]  ld_data = '0;
    logic         ld_ready;
    logic         ex_valid = 1'b0;
    logic         ex_mode = 1'b0;
    logic [3:0]   ex_addr = '0;
    logic [7:0]   ex_lane_en = '0;
    logic         bc_valid;
    logic         bc_mode;
    logic [7:0]   bc_lane_vld;
    logic [255:0] bc_ctx;
    logic         wr_conflict;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ctx_bcast_mem i_ctx_bcast_mem (
        .clk(clk), .rst(rst),
        .ld_start(ld_start), .ld_bank(ld_bank), .ld_set(ld_set),
        .ld_base(ld_base), .ld_count(ld_count), .ld_valid(ld_valid),
        .ld_data(ld_data), .ld_ready(ld_ready),
        .ex_valid(ex_valid), .ex_mode(ex_mode), .ex_addr(ex_addr),
        .ex_lane_en(ex_lane_en),
        .bc_valid(bc_valid), .bc_mode(bc_mode), .bc_lane_vld(bc_lane_vld),
        .bc_ctx(bc_ctx), .wr_conflict(wr_conflict)
    );

    function automatic logic [31:0] pat(int bank, int set, int idx, int tag);
        return {8'(tag), 3'b0, 1'(bank), 1'b0, 3'(set), 4'(idx), 4'h0, 8'h5A};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_mem [2][8][16];
    logic [31:0] m_ctx [8];
    logic        m_bcv, m_mode, m_conf, m_busy, m_bank;
    logic [7:0]  m_lv;
    int          m_set, m_ptr, m_left;

    always @(posedge clk) begin
        if (rst) begin
            m_bcv = 0; m_mode = 0; m_conf = 0; m_lv = 0; m_busy = 0;
            for (int i = 0; i < 8; i++) m_ctx[i] = '0;
        end else begin
            bit acc;
            acc = m_busy && ld_valid;
            if (ex_valid) begin
                for (int i = 0; i < 8; i++)
                    if (ex_lane_en[i]) m_ctx[i] = m_mem[ex_mode][i][ex_addr];
                m_mode = ex_mode;
            end
            m_bcv  = ex_valid;
            m_lv   = ex_valid ? ex_lane_en : 8'h00;
            m_conf = acc && ex_valid && (ex_mode == m_bank);
            if (acc) begin
                m_mem[m_bank][m_set][m_ptr] = ld_data;
                m_ptr = (m_ptr + 1) % 16;
                m_left--;
                if (m_left == 0) m_busy = 0;
            end else if (!m_busy && ld_start && ld_count >= 1 && ld_count <= 16) begin
                m_busy = 1; m_bank = ld_bank; m_set = ld_set;
                m_ptr = ld_base; m_left = ld_count;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R2 ld_ready", 32'(ld_ready), 32'(m_busy));
            chk("R7 bc_valid", 32'(bc_valid), 32'(m_bcv));
            chk("R7 bc_mode", 32'(bc_mode), 32'(m_mode));
            chk("R6 bc_lane_vld", 32'(bc_lane_vld), 32'(m_lv));
            chk("R9 wr_conflict", 32'(wr_conflict), 32'(m_conf));
            for (int i = 0; i < 8; i++)
                chk(m_mode ? "R5 column lane" : "R4 row lane", bc_ctx[i*32 +: 32], m_ctx[i]);
        end
    end

    task automatic finish_up();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #400000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    task automatic load(int bank, int set, int base, int count, int tag, bit gap);
        @(negedge clk);
        ld_start = 1; ld_bank = 1'(bank); ld_set = 3'(set);
        ld_base = 4'(base); ld_count = 5'(count);
        @(negedge clk);
        ld_start = 0;
        for (int k = 0; k < count; k++) begin
            if (gap && k == 1) begin
                ld_valid = 0;
                @(negedge clk);
            end
            ld_valid = 1;
            ld_data = pat(bank, set, (base + k) % 16, tag);
            @(negedge clk);
        end
        ld_valid = 0;
    endtask

    task automatic exec(int mode, int addr, int en);
        @(negedge clk);
        ex_valid = 1; ex_mode = 1'(mode); ex_addr = 4'(addr); ex_lane_en = 8'(en);
        @(negedge clk);
        ex_valid = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: state just after reset
        chk("R1 bc_valid", 32'(bc_valid), 0);
        chk("R1 bc_mode", 32'(bc_mode), 0);
        chk("R1 bc_lane_vld", 32'(bc_lane_vld), 0);
        chk("R1 ld_ready", 32'(ld_ready), 0);
        chk("R1 wr_conflict", 32'(wr_conflict), 0);
        chk("R1 bc_ctx", 32'(bc_ctx != '0), 0);

        for (int s = 0; s < 8; s++) load(0, s, 0, 16, 1, s == 3);
        for (int s = 0; s < 8; s++) load(1, s, 5, 16, 2, 0);   // R3 wrap from index 5

        exec(0, 3, 8'hFF);
        for (int i = 0; i < 8; i++) chk("R4 row directed", bc_ctx[i*32 +: 32], pat(0, i, 3, 1));
        exec(1, 2, 8'hFF);
        for (int i = 0; i < 8; i++) chk("R5 column directed", bc_ctx[i*32 +: 32], pat(1, i, 2, 2));
        exec(0, 7, 8'h0F);
        chk("R6 held lane", bc_ctx[6*32 +: 32], pat(1, 6, 2, 2));
        chk("R6 updated lane", bc_ctx[1*32 +: 32], pat(0, 1, 7, 1));

        // R3: short wrapping burst 14,15,0,1 in column set 3
        load(1, 3, 14, 4, 3, 0);
        exec(1, 1, 8'h0C);
        chk("R3 wrapped word", bc_ctx[3*32 +: 32], pat(1, 3, 1, 3));
        chk("R3 neighbour set", bc_ctx[2*32 +: 32], pat(1, 2, 1, 2));
        exec(1, 13, 8'h08);
        chk("R3 untouched index", bc_ctx[3*32 +: 32], pat(1, 3, 13, 2));

        // R2: illegal counts ignored
        @(negedge clk);
        ld_start = 1; ld_count = 0;
        @(negedge clk);
        ld_start = 1; ld_count = 17;
        @(negedge clk);
        ld_start = 0;
        chk("R2 bad count ignored", 32'(ld_ready), 0);

        // R8 + R9: write and read same bank/set/index in one cycle
        @(negedge clk);
        ld_start = 1; ld_bank = 0; ld_set = 0; ld_base = 9; ld_count = 1;
        @(negedge clk);
        ld_start = 0; ld_valid = 1; ld_data = pat(0, 0, 9, 4);
        ex_valid = 1; ex_mode = 0; ex_addr = 9; ex_lane_en = 8'h01;
        @(negedge clk);
        ld_valid = 0; ex_valid = 0;
        chk("R8 old word read", bc_ctx[31:0], pat(0, 0, 9, 1));
        chk("R9 conflict flagged", 32'(wr_conflict), 1);
        exec(0, 9, 8'h01);
        chk("R8 new word later", bc_ctx[31:0], pat(0, 0, 9, 4));

        // R10: reload row set 2 while column executes run
        @(negedge clk);
        ld_start = 1; ld_bank = 0; ld_set = 2; ld_base = 0; ld_count = 6;
        @(negedge clk);
        ld_start = 0;
        for (int k = 0; k < 6; k++) begin
            ld_valid = 1; ld_data = pat(0, 2, k, 5);
            ex_valid = 1; ex_mode = 1; ex_addr = 4'(k + 6); ex_lane_en = 8'hFF;
            @(negedge clk);
            chk("R10 no conflict", 32'(wr_conflict), 0);
            chk("R10 column intact", bc_ctx[2*32 +: 32], pat(1, 2, k + 6, 2));
        end
        ld_valid = 0; ex_valid = 0;
        exec(0, 4, 8'h04);
        chk("R10 reload landed", bc_ctx[2*32 +: 32], pat(0, 2, 4, 5));

        // mixed pattern sweep, compared by the model each clock
        for (int j = 0; j < 48; j++) begin
            @(negedge clk);
            ex_valid = (j % 5) != 4;
            ex_mode = 1'(j % 2);
            ex_addr = 4'((j * 7) % 16);
            ex_lane_en = 8'((j * 37 + 11) % 256);
        end
        @(negedge clk);
        ex_valid = 0;
        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule